// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor

This block watches a received dual-rail line stream, one bit per clock, and keeps a loss-of-signal (LOS) indication for the receive path. A bit period with no pulse on either rail is a zero. The internal detector raises its LOS cause after a long unbroken run of zeros. It drops that cause only after the line has stayed busy for a full window. A separate LOS flag from the line interface device is ORed in, so either source can hold the status high.

Every transition of the combined status, rising or falling, latches a pending-change bit. That bit stays set until software reads the status location. The interrupt pin is that pending bit masked by two enables: a per-source LOS enable, and a block enable for the whole receive section. A four-word register window holds the detector enable, the two interrupt enables and the status word.

Top module: `los_monitor`

## Requirements
- R1: A bit counts as zero only when `rx_pos` and `rx_neg` are both 0; a pulse on either rail, or on both, counts as a one and restarts the zero run.
- R2: With the detector enabled (address 0, bit 0 = 1), `los` goes to 1 on the clock that samples the 32nd consecutive zero; 31 zeros followed by a one do not declare it.
- R3: Once declared internally, the internal cause clears on the 32nd consecutive bit that does not end a run of four or more zeros. Any bit that ends such a run restarts the count, and a run of three zeros does not.
- R4: `ext_los` high forces `los` to 1 one clock after it is sampled. When it returns low, `los` still follows the internal cause.
- R5: With the detector disabled (address 0, bit 0 = 0), the internal cause is forced clear on the next clock and zeros have no effect on `los`.
- R6: Every change of `los`, whether 0 to 1 or 1 to 0, sets the pending-change bit (address 3, bit 0) one clock later.
- R7: A read of address 3 returns the pending bit and then clears it. If a new change arrives in the same clock, the pending bit stays set.
- R8: `irq` is 1 exactly when the pending bit is set, the source enable (address 1, bit 0) is 1 and the block enable (address 2, bit 0) is 1.
- R9: Reads return the writable enable bits at bit 0 of addresses 0 to 2 and the live `los` value at address 3, bit 1. All other bits read 0, and writes to address 3 have no effect.
- R10: After reset, all enables and the pending bit are 0 and `los` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_pos | input | 1 | Positive-rail pulse for this bit |
| rx_neg | input | 1 | Negative-rail pulse for this bit |
| ext_los | input | 1 | LOS flag from the line interface device |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears pending on address 3) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the strobe cycle |
| los | output | 1 | Combined loss-of-signal status |
| irq | output | 1 | Gated change-of-LOS interrupt |

## Verification
A zero-run or window counter that is off by one moves the declare or clear edge of `los` by whole bit periods. The bench sweeps run lengths and clean-window positions and checks the exact bit on which `los` flips. A pending bit that is lost, cleared too early or set twice shows on `irq` within one clock of the status change or of the status read. Gating faults appear as `irq` disagreeing with the enable combination in the same cycle.

// File: rtl/los_pkg.sv
package los_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    typedef enum logic [REG_AW-1:0] {
        REG_CFG    = 2'd0,
        REG_SRC_IE = 2'd1,
        REG_BLK_IE = 2'd2,
        REG_STAT   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic det_en;
        logic src_ie;
        logic blk_ie;
    } los_cfg_t;

    function automatic logic rail_is_zero(input logic pos, input logic neg);
        return ~(pos | neg);
    endfunction

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run
    import los_pkg::*;
#(
    parameter int DECLARE_RUN = 32,
    parameter int CLEAR_RUN   = 4,
    parameter int CLEAR_SPAN  = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic int_los
);
    localparam int RUN_W  = $clog2(DECLARE_RUN + 1);
    localparam int SPAN_W = $clog2(CLEAR_SPAN + 1);

    logic [RUN_W-1:0]  run_q, run_nxt;
    logic [SPAN_W-1:0] span_q, span_inc;
    logic              zero_bit, long_run, lost_q;

    always_comb begin
        zero_bit = rail_is_zero(rx_pos, rx_neg);
        if (!zero_bit)
            run_nxt = '0;
        else if (run_q == RUN_W'(DECLARE_RUN))
            run_nxt = run_q;
        else
            run_nxt = run_q + 1'b1;
        long_run = (run_nxt >= RUN_W'(CLEAR_RUN));
        span_inc = span_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run_q  <= '0;
            span_q <= '0;
            lost_q <= 1'b0;
        end else begin
            run_q <= run_nxt;
            if (!lost_q) begin
                span_q <= '0;
                if (run_nxt == RUN_W'(DECLARE_RUN))
                    lost_q <= 1'b1;
            end else if (long_run) begin
                span_q <= '0;
            end else if (span_inc == SPAN_W'(CLEAR_SPAN)) begin
                span_q <= '0;
                lost_q <= 1'b0;
            end else begin
                span_q <= span_inc;
            end
        end
    end

    assign int_los = lost_q;
endmodule

// File: rtl/los_ext_sync.sv
module los_ext_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/los_event.sv
module los_event (
    input  logic clk,
    input  logic rst,
    input  logic los_now,
    input  logic clr_req,
    output logic change,
    output logic pend
);
    logic prev_q, pend_q;

    assign change = los_now ^ prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= los_now;
            if (change)       pend_q <= 1'b1;
            else if (clr_req) pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/los_csr.sv
module los_csr
    import los_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              pend,
    input  logic              los_now,
    output logic [REG_DW-1:0] rdata,
    output los_cfg_t          cfg,
    output logic              clr_req
);
    los_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_CFG:    cfg_q.det_en <= wdata[0];
                REG_SRC_IE: cfg_q.src_ie <= wdata[0];
                REG_BLK_IE: cfg_q.blk_ie <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CFG:    rdata[0] = cfg_q.det_en;
            REG_SRC_IE: rdata[0] = cfg_q.src_ie;
            REG_BLK_IE: rdata[0] = cfg_q.blk_ie;
            REG_STAT: begin
                rdata[0] = pend;
                rdata[1] = los_now;
            end
            default: ;
        endcase
    end

    assign clr_req = rd_en && (addr == REG_STAT);
    assign cfg     = cfg_q;
endmodule

// File: rtl/los_monitor.sv
module los_monitor
    import los_pkg::*;
#(
    parameter int DECLARE_RUN = 32,
    parameter int CLEAR_RUN   = 4,
    parameter int CLEAR_SPAN  = 32,
    parameter int EXT_STAGES  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_pos,
    input  logic              rx_neg,
    input  logic              ext_los,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              los,
    output logic              irq
);
    los_cfg_t cfg;
    logic     int_los, ext_los_q, change, pend, clr_req;

    los_zero_run #(
        .DECLARE_RUN (DECLARE_RUN),
        .CLEAR_RUN   (CLEAR_RUN),
        .CLEAR_SPAN  (CLEAR_SPAN)
    ) u_run (
        .clk     (clk),
        .rst     (rst),
        .enable  (cfg.det_en),
        .rx_pos  (rx_pos),
        .rx_neg  (rx_neg),
        .int_los (int_los)
    );

    los_ext_sync #(.STAGES(EXT_STAGES)) u_ext (
        .clk (clk),
        .rst (rst),
        .d   (ext_los),
        .q   (ext_los_q)
    );

    assign los = int_los | ext_los_q;

    los_event u_evt (
        .clk     (clk),
        .rst     (rst),
        .los_now (los),
        .clr_req (clr_req),
        .change  (change),
        .pend    (pend)
    );

    los_csr u_csr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .rd_en   (reg_rd),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .pend    (pend),
        .los_now (los),
        .rdata   (reg_rdata),
        .cfg     (cfg),
        .clr_req (clr_req)
    );

    assign irq = pend & cfg.src_ie & cfg.blk_ie;
endmodule

// File: rtl/los_monitor_checker.sv
module los_monitor_checker (
    input logic clk,
    input logic rst,
    input logic rx_pos,
    input logic rx_neg,
    input logic ext_los_q,
    input logic int_los,
    input logic det_en,
    input logic src_ie,
    input logic blk_ie,
    input logic los,
    input logic change,
    input logic pend,
    input logic clr_req,
    input logic irq
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R2: the internal cause only rises right after a zero bit was sampled
    assert_rise_on_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(int_los)) |-> $past(!rx_pos && !rx_neg));

    // R5: a disabled detector holds its cause clear
    assert_disable_clears_R5: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> !int_los);

    // R4: the external flag alone holds the status up
    assert_ext_forces_los_R4: assert property (@(posedge clk) disable iff (rst)
        ext_los_q |-> los);

    // R6: any status change leaves the pending bit set
    assert_change_sets_pend_R6: assert property (@(posedge clk) disable iff (rst)
        change |=> pend);

    // R7: a status read with no new change empties the pending bit
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !change) |=> !pend);

    // R8: the interrupt never shows with either enable off
    assert_irq_needs_enables_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (src_ie && blk_ie && pend));
endmodule

bind los_monitor los_monitor_checker u_los_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_pos    (rx_pos),
    .rx_neg    (rx_neg),
    .ext_los_q (ext_los_q),
    .int_los   (int_los),
    .det_en    (cfg.det_en),
    .src_ie    (cfg.src_ie),
    .blk_ie    (cfg.blk_ie),
    .los       (los),
    .change    (change),
    .pend      (pend),
    .clr_req   (clr_req),
    .irq       (irq)
);

// File: tb/test_los_monitor.sv
`timescale 1ns/1ps
module test_los_monitor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_pos = 1'b1, rx_neg = 1'b0, ext_los = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       los, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    los_monitor i_los_monitor (
        .clk(clk), .rst(rst), .rx_pos(rx_pos), .rx_neg(rx_neg), .ext_los(ext_los),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .los(los), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send_bit(input logic p, input logic n);
        rx_pos = p;
        rx_neg = n;
        @(negedge clk);
    endtask

    task automatic send_ones(input int cnt);
        for (int i = 0; i < cnt; i++) send_bit(1'b1, 1'b0);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int exp_idx;
        logic zb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        check("R10 los", los, 0);
        check("R10 irq", irq, 0);
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), v);
            check("R10 reg", v, 0);
        end

        // R9: read-back of writable and fixed bits
        reg_write(2'd0, 8'hFF); reg_read(2'd0, v); check("R9 cfg", v, 1);
        reg_write(2'd1, 8'hFF); reg_read(2'd1, v); check("R9 src", v, 1);
        reg_write(2'd2, 8'hFF); reg_read(2'd2, v); check("R9 blk", v, 1);
        reg_write(2'd3, 8'hFF); reg_read(2'd3, v); check("R9 stat", v, 0);

        // R2: sweep run length of zeros
        for (int n = 1; n <= 40; n++) begin
            for (int i = 1; i <= n; i++) begin
                send_bit(1'b0, 1'b0);
                if (i == 31) check("R2 no declare at 31", los, 0);
                if (i == 32) check("R2 declare at 32", los, 1);
            end
            check("R2 end of run", los, (n >= 32) ? 1 : 0);
            for (int j = 1; j <= 40; j++) begin
                send_bit(1'b1, 1'b0);
                if (n >= 32 && j == 1)  check("R6 declare raises irq", irq, 1);
                if (n >= 32 && j == 31) check("R3 held at 31", los, 1);
                if (n >= 32 && j == 32) check("R3 cleared at 32", los, 0);
                if (n >= 32 && j == 33) check("R6 clear raises irq", irq, 1);
                if (n < 32 && j == 40)  check("R6 no change no irq", irq, 0);
            end
            reg_read(2'd3, v);
        end

        // R1: every non-zero rail code breaks the run
        for (int t = 1; t < 4; t++) begin
            for (int i = 0; i < 31; i++) send_bit(1'b0, 1'b0);
            send_bit(t[1], t[0]);
            for (int i = 0; i < 31; i++) send_bit(1'b0, 1'b0);
            check("R1 run broken by pulse", los, 0);
            send_bit(1'b0, 1'b0);
            check("R1 run restarted after pulse", los, 1);
            send_ones(40);
            reg_read(2'd3, v);
        end

        // R3: clean-window restart sweep
        for (int z = 3; z <= 5; z++) begin
            for (int k = 1; k <= 20; k++) begin
                for (int i = 0; i < 32; i++) send_bit(1'b0, 1'b0);
                exp_idx = (z >= 4) ? (k + z + 32) : 32;
                for (int t = 1; t <= exp_idx + 2; t++) begin
                    zb = (t > k) && (t <= k + z);
                    send_bit(!zb, 1'b0);
                    if (t == exp_idx - 1) check("R3 window not done", los, 1);
                    if (t == exp_idx)     check("R3 window done", los, 0);
                end
                reg_read(2'd3, v);
            end
        end

        // R4: external flag ORed with the internal cause
        for (int i = 0; i < 32; i++) send_bit(1'b0, 1'b0);
        ext_los = 1'b1; send_bit(1'b0, 1'b0);
        ext_los = 1'b0; send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
        check("R4 internal keeps los", los, 1);
        send_ones(32);
        check("R4 both causes gone", los, 0);
        send_ones(2);
        reg_read(2'd3, v);

        // R8 / R6 / R7: gating sweep with the external flag
        for (int g = 0; g < 4; g++) begin
            reg_write(2'd1, {7'd0, g[1]});
            reg_write(2'd2, {7'd0, g[0]});
            reg_read(2'd3, v);
            ext_los = 1'b1;
            send_bit(1'b1, 1'b0);
            check("R4 ext declares", los, 1);
            send_bit(1'b1, 1'b0);
            check("R8 gate on declare", irq, g[1] & g[0]);
            reg_read(2'd3, v);
            check("R7 pending read", v, 3);
            check("R7 cleared after read", irq, 0);
            ext_los = 1'b0;
            send_bit(1'b1, 1'b0);
            check("R4 ext removed", los, 0);
            send_bit(1'b1, 1'b0);
            check("R8 gate on clear", irq, g[1] & g[0]);
            reg_read(2'd3, v);
            check("R6 pending on clear", v[0], 1);
        end

        // R7: change and read in the same clock keep the pending bit
        reg_write(2'd1, 8'd1);
        reg_write(2'd2, 8'd1);
        reg_read(2'd3, v);
        ext_los = 1'b1;
        send_bit(1'b1, 1'b0);
        reg_read(2'd3, v);
        check("R7 read before set", v[0], 0);
        check("R7 set wins over clear", irq, 1);
        reg_read(2'd3, v);
        ext_los = 1'b0;
        send_ones(3);
        reg_read(2'd3, v);
        check("R7 idle after reads", irq, 0);

        // R5: disabling the detector drops the internal cause
        for (int i = 0; i < 32; i++) send_bit(1'b0, 1'b0);
        check("R5 declared before disable", los, 1);
        reg_write(2'd0, 8'd0);
        send_bit(1'b0, 1'b0);
        check("R5 cleared by disable", los, 0);
        for (int i = 0; i < 40; i++) send_bit(1'b0, 1'b0);
        check("R5 zeros ignored while off", los, 0);
        reg_read(2'd0, v);
        check("R5 enable reads off", v, 0);

        finish_run();
    end
endmodule